// File: doc/BRIEF.md
# Packet Line-Window Stream Port

This block moves a single packet between a 512-line by 32-bit buffer RAM and a word stream. The RAM sits outside the block, which drives it through an enable, a write enable, an address, write data and read data. A 32-bit command word names a window of lines (a first line and a last line) and a direction. The command is applied by a one-cycle `cmdGo` strobe.

In read mode the block fetches lines ahead of the consumer. It presents each line with start and end markers through a ready/read handshake. In write mode it takes flagged words through a ready/write handshake and stores them at consecutive lines. A window whose last line is below its first line runs past line 511 and continues at line 0.

A transfer ends with `done` or `error`, and that flag stays set until the next command. A command with the clear bit set aborts whatever is in progress.

Top module: `pkt_window_port`

## Requirements
- R1: The command word is acted on only in a cycle where `cmdGo` is high. Its fields are first line in bits 8:0, last line in bits 17:9, read in bit 22, write in bit 23 and clear in bit 24. Bits 21:18 and bits 31:25 have no effect on behaviour.
- R2: After reset, `done`, `error`, `rdReady`, `wrReady`, `ramEn` and `ramWe` are all low.
- R3: A transfer covers the lines from first to last inclusive, in rising order, and wraps from line 511 to line 0. The line count is ((last - first) mod 512) + 1.
- R4: In read mode, `rdReady` is high from the second clock edge after the go edge. `rdData` then carries the current line. A line is consumed only on an edge where `rdReady` and `rdRead` are both high, and any number of idle cycles may separate reads.
- R5: While `rdReady` is high, `rdFlags` bit 0 marks the first line of the window and bit 1 marks the last line. While `rdReady` is low, `rdFlags` is zero.
- R6: Consuming the last line raises `done` and drops `rdReady`. `done` then stays high until the next go.
- R7: If `rdError` is high on an edge where a line is consumed, the transfer ends with `error` high and `done` low. `error` stays high until the next go.
- R8: In write mode, `wrReady` is high until the transfer ends. Each accepted word is stored at the next line of the window with one `ramWe` cycle. Once the last line is stored, `done` rises and `wrReady` drops.
- R9: A word accepted with `wrFlags` bit 1 (end of packet) before the last line is stored and then ends the transfer with `done`.
- R10: A word with both `wrFlags` bit 0 and bit 1 set that arrives at any line other than the first is not stored, and it ends the transfer with `error`.
- R11: A go with the clear bit set, or with neither read nor write set, returns the block to idle. `done`, `error`, `rdReady` and `wrReady` are low from the next cycle on.
- R12: A reader that stops consuming before the last line leaves the block waiting, with `rdReady` high and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdWord | input | 32 | Command: window, direction, clear |
| cmdGo | input | 1 | One-cycle strobe that applies cmdWord |
| done | output | 1 | Transfer finished normally |
| error | output | 1 | Transfer ended by an error |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 9 | RAM line address |
| ramWrData | output | 32 | Data written to RAM |
| ramRdData | input | 32 | RAM read data, one cycle after the access |
| wrData | input | 32 | Incoming stream word |
| wrFlags | input | 4 | Bit 0 start, bit 1 end of packet |
| wrWrite | input | 1 | Producer offers a word |
| wrReady | output | 1 | Block accepts a word |
| rdData | output | 32 | Outgoing line |
| rdFlags | output | 4 | Bit 0 start, bit 1 end of packet |
| rdReady | output | 1 | Outgoing line valid |
| rdRead | input | 1 | Consumer takes the line |
| rdError | input | 1 | Consumer aborts with error |

## Verification
Reads are exercised with back-to-back consumption and with idle gaps. This separates a prefetch that keeps pace from one that repeats or skips a line. Windows are placed in mid-buffer, ending at line 511, covering the whole buffer, wrapping past zero, and covering a single line. Together these show whether the wrap, the line count and the flag placement are right, including the case where the start and end markers fall on the same word. Writes are read back from the RAM, and the same lines are then read through the block. Early end-of-packet, a mid-packet double-flag word, a consumer error, a stalled reader and clear commands show that each ending leaves the right flag and the right RAM contents.

// File: rtl/pkt_window_pkg.sv
package pkt_window_pkg;

  localparam int LINE_AW = 9;
  localparam int DATA_W  = 32;
  localparam int FLAG_W  = 4;
  localparam int CMD_W   = 32;
  localparam int STEP_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FETCH,
    ST_RD_AVAIL,
    ST_WR_OPEN,
    ST_DONE,
    ST_FAULT
  } winState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWin;   // capture window, point at first line
    logic advance;   // step current line by one
    logic fetch;     // read access this cycle
    logic store;     // write access this cycle
  } dpStrobe_t;

endpackage

// File: rtl/pkt_window_dp.sv
module pkt_window_dp
  import pkt_window_pkg::*;
#(
  parameter int AW = LINE_AW,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] cmdFirst,
  input  logic [AW-1:0] cmdLast,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] ramRdData,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWrData,
  output logic [DW-1:0] rdData,
  output logic          atFirst,
  output logic          atLast
);

  localparam logic [AW-1:0] TOP_LINE = '1;

  logic [AW-1:0] curLine;
  logic [AW-1:0] firstLine;
  logic [AW-1:0] lastLine;
  logic [AW-1:0] nextLine;

  // modulo-2^AW increment gives the wrap for free
  assign nextLine = curLine + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      curLine   <= '0;
      firstLine <= '0;
      lastLine  <= '0;
    end else if (strobe.loadWin) begin
      curLine   <= cmdFirst;
      firstLine <= cmdFirst;
      lastLine  <= cmdLast;
    end else if (strobe.advance) begin
      curLine   <= nextLine;
    end
  end

  // a read that advances prefetches the following line;
  // a write always lands on the current line
  assign ramAddr   = (strobe.advance && !strobe.store) ? nextLine : curLine;
  assign ramWrData = wrData;
  assign rdData    = ramRdData;
  assign atFirst   = (curLine == firstLine);
  assign atLast    = (curLine == lastLine);

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !strobe.loadWin && curLine == TOP_LINE) |=> (curLine == '0)); // R3

endmodule

// File: rtl/pkt_window_ctrl.sv
module pkt_window_ctrl
  import pkt_window_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdGo,
  input  logic      cmdRead,
  input  logic      cmdWrite,
  input  logic      cmdClear,
  input  logic      atFirst,
  input  logic      atLast,
  input  logic      rdRead,
  input  logic      rdError,
  input  logic      wrWrite,
  input  logic      wrSop,
  input  logic      wrEop,
  output dpStrobe_t strobe,
  output logic      ramEn,
  output logic      ramWe,
  output logic      rdReady,
  output logic      wrReady,
  output logic      rdSop,
  output logic      rdEop,
  output logic      done,
  output logic      error
);

  winState_e state;
  winState_e stateNxt;
  logic      wrBad;

  // both markers on a word that is not the packet's first
  assign wrBad = wrSop && wrEop && !atFirst;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_RD_FETCH: begin
        strobe.fetch = 1'b1;
        stateNxt     = ST_RD_AVAIL;
      end
      ST_RD_AVAIL: begin
        if (rdRead) begin
          if (rdError) begin
            stateNxt = ST_FAULT;
          end else if (atLast) begin
            stateNxt = ST_DONE;
          end else begin
            strobe.advance = 1'b1;
            strobe.fetch   = 1'b1;
          end
        end
      end
      ST_WR_OPEN: begin
        if (wrWrite) begin
          if (wrBad) begin
            stateNxt = ST_FAULT;
          end else begin
            strobe.store = 1'b1;
            if (wrEop || atLast) stateNxt = ST_DONE;
            else                 strobe.advance = 1'b1;
          end
        end
      end
      default: ;
    endcase
    // a new command overrides whatever the current state asked for
    if (cmdGo) begin
      strobe = '0;
      if (cmdClear) begin
        stateNxt = ST_IDLE;
      end else if (cmdRead) begin
        strobe.loadWin = 1'b1;
        stateNxt       = ST_RD_FETCH;
      end else if (cmdWrite) begin
        strobe.loadWin = 1'b1;
        stateNxt       = ST_WR_OPEN;
      end else begin
        stateNxt = ST_IDLE;
      end
    end
  end

  assign ramEn   = strobe.fetch || strobe.store;
  assign ramWe   = strobe.store;
  assign rdReady = (state == ST_RD_AVAIL);
  assign wrReady = (state == ST_WR_OPEN);
  assign rdSop   = rdReady && atFirst;
  assign rdEop   = rdReady && atLast;
  assign done    = (state == ST_DONE);
  assign error   = (state == ST_FAULT);

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !cmdGo) |=> done); // R6

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (error && !cmdGo) |=> (error && !done)); // R7

  AST_WE_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (wrWrite && wrReady && !cmdGo)); // R8

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmdGo && cmdClear) |=> !(done || error || rdReady || wrReady)); // R11

endmodule

// File: rtl/pkt_window_port.sv
module pkt_window_port
  import pkt_window_pkg::*;
#(
  parameter int AW = LINE_AW,
  parameter int DW = DATA_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   cmdWord,
  input  logic          cmdGo,
  output logic          done,
  output logic          error,
  output logic          ramEn,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWrData,
  input  logic [DW-1:0] ramRdData,
  input  logic [DW-1:0] wrData,
  input  logic [FW-1:0] wrFlags,
  input  logic          wrWrite,
  output logic          wrReady,
  output logic [DW-1:0] rdData,
  output logic [FW-1:0] rdFlags,
  output logic          rdReady,
  input  logic          rdRead,
  input  logic          rdError
);

  localparam int LAST_LSB  = AW;
  localparam int STEP_LSB  = 2 * AW;
  localparam int READ_BIT  = STEP_LSB + STEP_W;
  localparam int WRITE_BIT = READ_BIT + 1;
  localparam int CLEAR_BIT = WRITE_BIT + 1;

  dpStrobe_t     strobe;
  logic          atFirst;
  logic          atLast;
  logic          rdSop;
  logic          rdEop;
  logic          cmdUnused;
  logic [AW-1:0] cmdFirst;
  logic [AW-1:0] cmdLast;

  assign cmdFirst  = cmdWord[AW-1:0];
  assign cmdLast   = cmdWord[LAST_LSB +: AW];
  // step and upper command bits, plus the spare stream flags, carry no meaning
  assign cmdUnused = ^{cmdWord[31:CLEAR_BIT+1], cmdWord[STEP_LSB +: STEP_W], wrFlags[FW-1:2]};

  pkt_window_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .cmdGo    (cmdGo),
    .cmdRead  (cmdWord[READ_BIT]),
    .cmdWrite (cmdWord[WRITE_BIT]),
    .cmdClear (cmdWord[CLEAR_BIT]),
    .atFirst  (atFirst),
    .atLast   (atLast),
    .rdRead   (rdRead),
    .rdError  (rdError),
    .wrWrite  (wrWrite),
    .wrSop    (wrFlags[0]),
    .wrEop    (wrFlags[1]),
    .strobe   (strobe),
    .ramEn    (ramEn),
    .ramWe    (ramWe),
    .rdReady  (rdReady),
    .wrReady  (wrReady),
    .rdSop    (rdSop),
    .rdEop    (rdEop),
    .done     (done),
    .error    (error)
  );

  pkt_window_dp #(.AW(AW), .DW(DW)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cmdFirst  (cmdFirst),
    .cmdLast   (cmdLast),
    .wrData    (wrData),
    .ramRdData (ramRdData),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .rdData    (rdData),
    .atFirst   (atFirst),
    .atLast    (atLast)
  );

  assign rdFlags = {{(FW-2){1'b0}}, rdEop, rdSop};

  AST_ONE_ENDING: assert property (@(posedge clk) disable iff (rst)
    !(done && error) && !(rdReady && wrReady)); // R7

endmodule

// File: tb/pkt_window_port_tb_top.sv
module pkt_window_port_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cmdWord = '0;
  logic        cmdGo = 1'b0;
  logic        done, error, ramEn, ramWe, wrReady, rdReady;
  logic [8:0]  ramAddr;
  logic [31:0] ramWrData, rdData;
  logic [31:0] ramRdQ = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrFlags = '0;
  logic [3:0]  rdFlags;
  logic        wrWrite = 1'b0, rdRead = 1'b0, rdError = 1'b0;

  logic [31:0] ramMem [512];
  logic [31:0] shadow [512];
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pkt_window_port dut_i (
    .clk(clk), .rst(rst), .cmdWord(cmdWord), .cmdGo(cmdGo),
    .done(done), .error(error),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramRdData(ramRdQ),
    .wrData(wrData), .wrFlags(wrFlags), .wrWrite(wrWrite), .wrReady(wrReady),
    .rdData(rdData), .rdFlags(rdFlags), .rdReady(rdReady),
    .rdRead(rdRead), .rdError(rdError)
  );

  function automatic logic [31:0] initVal(int i);
    return {16'hBEEF, 7'd0, i[8:0]};
  endfunction

  // bench RAM, one cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) ramMem[i] <= initVal(i);
    end else if (ramEn) begin
      if (ramWe) ramMem[ramAddr] <= ramWrData;
      else       ramRdQ <= ramMem[ramAddr];
    end
  end

  // isWrite, junk, waits[3:0], first[8:0], last[8:0]
  localparam int NVEC = 10;
  localparam logic [23:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 4'd0, 9'd5,   9'd10},
    {1'b0, 1'b1, 4'd2, 9'd5,   9'd10},
    {1'b0, 1'b0, 4'd0, 9'd500, 9'd511},
    {1'b0, 1'b0, 4'd0, 9'd505, 9'd3},
    {1'b0, 1'b0, 4'd0, 9'd0,   9'd511},
    {1'b1, 1'b0, 4'd1, 9'd10,  9'd15},
    {1'b1, 1'b1, 4'd0, 9'd508, 9'd4},
    {1'b0, 1'b0, 4'd0, 9'd506, 9'd10},
    {1'b0, 1'b0, 4'd1, 9'd7,   9'd7},
    {1'b1, 1'b0, 4'd0, 9'd200, 9'd200}
  };

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(bit rd, bit wr, bit clr, int first, int last, bit junk);
    logic [8:0] f = first[8:0];
    logic [8:0] l = last[8:0];
    return {junk ? 7'h7F : 7'h00, clr, wr, rd, junk ? 4'hF : 4'h1, l, f};
  endfunction

  task automatic issueCmd(logic [31:0] w);
    @(negedge clk);
    cmdWord = w;
    cmdGo   = 1'b1;
    @(negedge clk);
    cmdGo   = 1'b0;
    cmdWord = junkWord();
  endtask

  // arbitrary pattern left on the command bus while go is low (R1)
  function automatic logic [31:0] junkWord();
    return 32'h01C0_0000;
  endfunction

  task automatic waitRd(string tag);
    for (int t = 0; t < 16 && !rdReady; t++) @(negedge clk);
    checkEq(tag, rdReady, 1'b1);
  endtask

  task automatic waitWr(string tag);
    for (int t = 0; t < 16 && !wrReady; t++) @(negedge clk);
    checkEq(tag, wrReady, 1'b1);
  endtask

  task automatic readLines(int first, int nLines, int total, int waits, string tag);
    for (int k = 0; k < nLines; k++) begin
      int line = (first + k) % 512;
      waitRd({tag, " R4 ready"});
      checkEq({tag, " R4 data"}, rdData, shadow[line]);
      checkEq({tag, " R5 flags"}, rdFlags, {30'd0, k == total - 1, k == 0});
      checkEq({tag, " R6 no early done"}, done, 1'b0);
      rdRead = 1'b1;
      @(negedge clk);
      rdRead = 1'b0;
      repeat (waits) @(negedge clk);
    end
  endtask

  task automatic writeWords(int first, int nWords, int waits, logic [31:0] base,
                            int eopIdx, int badIdx, string tag);
    for (int k = 0; k < nWords; k++) begin
      int line = (first + k) % 512;
      waitWr({tag, " R8 ready"});
      wrData  = base + k;
      wrFlags = {2'b00, k == eopIdx || k == badIdx, k == 0 || k == badIdx};
      if (k != badIdx) shadow[line] = base + k;
      wrWrite = 1'b1;
      @(negedge clk);
      wrWrite = 1'b0;
      wrFlags = '0;
      repeat (waits) @(negedge clk);
    end
  endtask

  task automatic checkRam(string tag);
    int mism = 0;
    for (int i = 0; i < 512; i++) if (ramMem[i] !== shadow[i]) mism++;
    checkEq(tag, mism, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) shadow[i] = initVal(i);
    repeat (4) @(negedge clk);
    // R2 reset state
    checkEq("R2 done", done, 1'b0);
    checkEq("R2 error", error, 1'b0);
    checkEq("R2 rdReady", rdReady, 1'b0);
    checkEq("R2 wrReady", wrReady, 1'b0);
    checkEq("R2 ramEn", ramEn, 1'b0);
    checkEq("R2 ramWe", ramWe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    cmdWord = mkCmd(1, 0, 0, 3, 9, 0);
    repeat (3) @(negedge clk);
    checkEq("R1 no go no action", rdReady, 1'b0);

    // table of windows
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] vec = VECS[v];
      int first = int'(vec[17:9]);
      int last  = int'(vec[8:0]);
      int waits = int'(vec[21:18]);
      int total = ((last - first + 512) % 512) + 1;
      if (!vec[23]) begin
        issueCmd(mkCmd(1, 0, 0, first, last, vec[22]));
        readLines(first, total, total, waits, $sformatf("vec%0d R3", v));
        checkEq($sformatf("vec%0d R6 done", v), done, 1'b1);
        checkEq($sformatf("vec%0d R6 rdReady low", v), rdReady, 1'b0);
      end else begin
        issueCmd(mkCmd(0, 1, 0, first, last, vec[22]));
        writeWords(first, total, waits, 32'hA500_0000 + (v << 12), total - 1, -1,
                   $sformatf("vec%0d R3", v));
        checkEq($sformatf("vec%0d R8 done", v), done, 1'b1);
        checkEq($sformatf("vec%0d R8 wrReady low", v), wrReady, 1'b0);
        checkRam($sformatf("vec%0d R8 ram", v));
      end
      repeat (5) @(negedge clk);
      checkEq($sformatf("vec%0d R6 done holds", v), done, 1'b1);
      checkEq($sformatf("vec%0d R7 no error", v), error, 1'b0);
    end

    // R4 ready timing, R12 stalled reader
    issueCmd(mkCmd(1, 0, 0, 20, 22, 0));
    checkEq("R4 not ready one edge after go", rdReady, 1'b0);
    @(negedge clk);
    checkEq("R4 ready two edges after go", rdReady, 1'b1);
    readLines(20, 2, 3, 0, "stall");
    repeat (6) @(negedge clk);
    checkEq("R12 still ready", rdReady, 1'b1);
    checkEq("R12 no done", done, 1'b0);
    checkEq("R5 eop on last line", rdFlags, 32'd2);
    checkEq("R12 data held", rdData, shadow[22]);

    // R11 clear aborts
    issueCmd(mkCmd(0, 0, 1, 0, 0, 0));
    checkEq("R11 rdReady low", rdReady, 1'b0);
    checkEq("R11 done low", done, 1'b0);
    checkEq("R5 flags zero when idle", rdFlags, 32'd0);

    // R7 consumer error
    issueCmd(mkCmd(1, 0, 0, 30, 40, 0));
    readLines(30, 3, 11, 0, "err");
    waitRd("R7 ready");
    rdError = 1'b1;
    rdRead  = 1'b1;
    @(negedge clk);
    rdError = 1'b0;
    rdRead  = 1'b0;
    checkEq("R7 error", error, 1'b1);
    checkEq("R7 no done", done, 1'b0);
    checkEq("R7 rdReady low", rdReady, 1'b0);
    repeat (4) @(negedge clk);
    checkEq("R7 error holds", error, 1'b1);

    // R9 early end of packet
    issueCmd(mkCmd(0, 1, 0, 100, 120, 0));
    checkEq("R11 go clears error", error, 1'b0);
    writeWords(100, 4, 0, 32'hC100_0000, 3, -1, "eop");
    checkEq("R9 done", done, 1'b1);
    checkEq("R9 wrReady low", wrReady, 1'b0);
    checkRam("R9 ram");

    // R10 mid-packet double flag
    issueCmd(mkCmd(0, 1, 0, 130, 140, 0));
    writeWords(130, 4, 0, 32'hD200_0000, -1, 3, "bad");
    checkEq("R10 error", error, 1'b1);
    checkEq("R10 no done", done, 1'b0);
    checkEq("R10 wrReady low", wrReady, 1'b0);
    checkRam("R10 ram");

    // R11 go with no mode bits
    issueCmd(mkCmd(0, 0, 0, 1, 2, 1));
    checkEq("R11 error cleared", error, 1'b0);
    checkEq("R11 wrReady low", wrReady, 1'b0);

    // read back the early-ended window through the block
    issueCmd(mkCmd(1, 0, 0, 100, 104, 0));
    readLines(100, 5, 5, 0, "R9 readback");
    checkEq("R6 done readback", done, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule